// File: doc/BRIEF.md
# Instruction Breakpoint Comparator Bank

This block holds a set of hardware breakpoint units that watch the instruction stream as it retires. Each unit keeps one value word and one control word, both written by software through a simple register write port. Every cycle the surrounding pipeline presents the retiring instruction's virtual address together with the current application context identifier, the operating-system context identifier, the virtual machine identifier and the privilege level. The bank answers one cycle later with a per-unit hit vector and a single combined breakpoint event.

A unit can be typed as an instruction address comparator, an application-context comparator, an OS-context comparator, a comparator that requires both context identifiers, a VMID comparator or a context-plus-VMID comparator. Every context-type kind also has a linked form. A linked context unit never raises an event itself; it only qualifies an address unit that names it, so a breakpoint can be made to fire at an address only while a chosen program, guest or program-within-guest is running. The fetch input carries a valid flag only: the bank always accepts a fetch and has no back-pressure, so the pipeline never stalls on it.

Top module: `bp_bank`

## Requirements
- R1: The `unit_count` output always equals the parameter N (2 to 16 units).
- R2: After reset every unit is disabled and both outputs are zero; a unit whose enable bit (control bit 0) is clear never hits.
- R3: Control kind 0 (bits 7:4) is an unlinked address comparator: it hits when fetch address bits above bit 1 equal the value word's; address bits 1:0 are ignored.
- R4: Control bits 3:1 are a privilege mask (bit 1 = level 0, bit 2 = level 1, bit 3 = level 2); a unit hits only at a permitted level, and privilege code 3 never hits.
- R5: Kinds 2, 4 and 6 compare the value word's low CTX_W bits with, respectively, the application context, the OS context, and both contexts (both must equal).
- R6: Kind 8 compares the value word's low VMID_W bits with the VMID.
- R7: Kind 10 requires the application context to equal the value's low CTX_W bits and the VMID to equal the next VMID_W bits.
- R8: Linked context kinds 3, 5, 7, 9 and 11 never set their own hit bit.
- R9: Kind 1 is a linked address comparator: it hits only when its address compare succeeds and the unit named by control bits 11:8 is enabled, of a linked context kind and matches its own context; a link to a disabled, non-linked-context or nonexistent unit never hits.
- R10: Outputs are registered: a fetch with `fetch_valid` high updates `unit_hit` and `bp_event` on the next edge, `bp_event` being the OR of the hit vector; a cycle without a valid fetch gives all zeros.
- R11: A register write to a unit index of N or above changes no unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_unit | input | 4 | Target unit index |
| wr_sel | input | 1 | 0 writes the value word, 1 writes the control word |
| wr_data | input | VAL_W | Write data (control word in bits 11:0) |
| fetch_valid | input | 1 | A retiring instruction is presented this cycle |
| fetch_va | input | VA_W | Instruction virtual address |
| ctx_app | input | CTX_W | Application context identifier |
| ctx_os | input | CTX_W | Operating-system context identifier |
| vmid | input | VMID_W | Virtual machine identifier |
| priv_lvl | input | 2 | Current privilege level |
| unit_count | output | 5 | Number of implemented units |
| unit_hit | output | N | Registered per-unit hit flags |
| bp_event | output | 1 | Registered combined breakpoint event |

## Verification
Addresses are presented equal to a programmed value, differing only in the two ignored low bits, and one word away, which separates a full compare from a word-granular one. Context patterns set the application and OS identifiers equal and unequal to each other so the three context kinds are told apart, and VMID patterns swap which half of the value word holds which field. Linked cases vary the named unit's kind, enable and context so that a missing qualification shows up as a spurious hit, and writes to an out-of-range index followed by a matching fetch expose index truncation.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef enum logic [3:0] {
    K_ADDR     = 4'd0,
    K_ADDR_LNK = 4'd1,
    K_APP      = 4'd2,
    K_APP_LNK  = 4'd3,
    K_OS       = 4'd4,
    K_OS_LNK   = 4'd5,
    K_BOTH     = 4'd6,
    K_BOTH_LNK = 4'd7,
    K_VM       = 4'd8,
    K_VM_LNK   = 4'd9,
    K_CV       = 4'd10,
    K_CV_LNK   = 4'd11
  } bp_kind_e;

  localparam int CTRL_W = 12;

  typedef struct packed {
    logic [3:0] link;
    logic [3:0] kind;
    logic [2:0] plmask;
    logic       en;
  } bp_ctrl_t;
endpackage

// File: rtl/bp_regs.sv
module bp_regs
  import bp_pkg::*;
#(
  parameter int N     = 4,
  parameter int VAL_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [3:0]                wr_unit,
  input  logic                      wr_sel,
  input  logic [VAL_W-1:0]          wr_data,
  output logic [N-1:0][VAL_W-1:0]   value_o,
  output bp_ctrl_t [N-1:0]          ctrl_o
);
  for (genvar i = 0; i < N; i++) begin : g_unit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        value_o[i] <= '0;
        ctrl_o[i]  <= '0;
      end else if (wr_en && (wr_unit == 4'(i))) begin
        if (wr_sel) ctrl_o[i]  <= bp_ctrl_t'(wr_data[CTRL_W-1:0]);
        else        value_o[i] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/bp_unit.sv
module bp_unit
  import bp_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int CTX_W  = 16,
  parameter int VMID_W = 16,
  parameter int VAL_W  = 32
) (
  input  logic [VAL_W-1:0]  value_i,
  input  bp_ctrl_t          ctrl_i,
  input  logic [VA_W-1:0]   va_i,
  input  logic [CTX_W-1:0]  app_i,
  input  logic [CTX_W-1:0]  os_i,
  input  logic [VMID_W-1:0] vmid_i,
  input  logic [1:0]        priv_i,
  output logic              solo_hit_o,
  output logic              addr_lnk_ok_o,
  output logic              ctx_ok_o
);
  logic addr_eq, app_eq, os_eq, vm_eq, cv_vm_eq;
  logic priv_ok, src_eq, kind_known, kind_linked;

  assign addr_eq  = (va_i[VA_W-1:2] == value_i[VA_W-1:2]);
  assign app_eq   = (app_i == value_i[CTX_W-1:0]);
  assign os_eq    = (os_i == value_i[CTX_W-1:0]);
  assign vm_eq    = (vmid_i == value_i[VMID_W-1:0]);
  assign cv_vm_eq = (vmid_i == value_i[CTX_W +: VMID_W]);

  always_comb begin
    case (priv_i)
      2'd0:    priv_ok = ctrl_i.plmask[0];
      2'd1:    priv_ok = ctrl_i.plmask[1];
      2'd2:    priv_ok = ctrl_i.plmask[2];
      default: priv_ok = 1'b0;
    endcase
  end

  always_comb begin
    kind_known = 1'b1;
    case (ctrl_i.kind)
      K_ADDR, K_ADDR_LNK: src_eq = addr_eq;
      K_APP,  K_APP_LNK:  src_eq = app_eq;
      K_OS,   K_OS_LNK:   src_eq = os_eq;
      K_BOTH, K_BOTH_LNK: src_eq = app_eq && os_eq;
      K_VM,   K_VM_LNK:   src_eq = vm_eq;
      K_CV,   K_CV_LNK:   src_eq = app_eq && cv_vm_eq;
      default: begin
        src_eq     = 1'b0;
        kind_known = 1'b0;
      end
    endcase
  end

  assign kind_linked   = ctrl_i.kind[0];
  assign solo_hit_o    = ctrl_i.en && priv_ok && kind_known && !kind_linked && src_eq;
  assign addr_lnk_ok_o = ctrl_i.en && priv_ok && (ctrl_i.kind == K_ADDR_LNK) && addr_eq;
  assign ctx_ok_o      = ctrl_i.en && kind_known && kind_linked &&
                         (ctrl_i.kind != K_ADDR_LNK) && src_eq;
endmodule

// File: rtl/bp_link.sv
module bp_link
  import bp_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N-1:0]       solo_hit_i,
  input  logic [N-1:0]       addr_lnk_ok_i,
  input  logic [N-1:0]       ctx_ok_i,
  input  logic [N-1:0][3:0]  link_i,
  output logic [N-1:0]       hit_o
);
  for (genvar i = 0; i < N; i++) begin : g_res
    logic tgt_ok;
    always_comb begin
      tgt_ok = 1'b0;
      for (int j = 0; j < N; j++) begin
        if (link_i[i] == 4'(j)) tgt_ok = ctx_ok_i[j];
      end
    end
    assign hit_o[i] = solo_hit_i[i] || (addr_lnk_ok_i[i] && tgt_ok);
  end
endmodule

// File: rtl/bp_bank.sv
module bp_bank
  import bp_pkg::*;
#(
  parameter int N      = 4,
  parameter int VA_W   = 32,
  parameter int CTX_W  = 16,
  parameter int VMID_W = 16,
  localparam int CV_W  = CTX_W + VMID_W,
  localparam int VAL_W = (VA_W > CV_W) ? VA_W : CV_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        wr_unit,
  input  logic              wr_sel,
  input  logic [VAL_W-1:0]  wr_data,
  input  logic              fetch_valid,
  input  logic [VA_W-1:0]   fetch_va,
  input  logic [CTX_W-1:0]  ctx_app,
  input  logic [CTX_W-1:0]  ctx_os,
  input  logic [VMID_W-1:0] vmid,
  input  logic [1:0]        priv_lvl,
  output logic [4:0]        unit_count,
  output logic [N-1:0]      unit_hit,
  output logic              bp_event
);
  logic [N-1:0][VAL_W-1:0] value_q;
  bp_ctrl_t [N-1:0]        ctrl_q;
  logic [N-1:0]            solo_hit, addr_lnk_ok, ctx_ok, hit_comb;
  logic [N-1:0][3:0]       link_idx;

  assign unit_count = 5'(N);

  bp_regs #(.N(N), .VAL_W(VAL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_unit(wr_unit),
    .wr_sel(wr_sel), .wr_data(wr_data), .value_o(value_q), .ctrl_o(ctrl_q)
  );

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign link_idx[i] = ctrl_q[i].link;
    bp_unit #(.VA_W(VA_W), .CTX_W(CTX_W), .VMID_W(VMID_W), .VAL_W(VAL_W)) u_unit (
      .value_i(value_q[i]), .ctrl_i(ctrl_q[i]), .va_i(fetch_va),
      .app_i(ctx_app), .os_i(ctx_os), .vmid_i(vmid), .priv_i(priv_lvl),
      .solo_hit_o(solo_hit[i]), .addr_lnk_ok_o(addr_lnk_ok[i]), .ctx_ok_o(ctx_ok[i])
    );
  end

  bp_link #(.N(N)) u_link (
    .solo_hit_i(solo_hit), .addr_lnk_ok_i(addr_lnk_ok), .ctx_ok_i(ctx_ok),
    .link_i(link_idx), .hit_o(hit_comb)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unit_hit <= '0;
      bp_event <= 1'b0;
    end else begin
      unit_hit <= fetch_valid ? hit_comb : '0;
      bp_event <= fetch_valid && (|hit_comb);
    end
  end
endmodule

// File: rtl/bp_bank_chk.sv
module bp_bank_chk #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         fetch_valid,
  input logic [1:0]   priv_lvl,
  input logic [4:0]   unit_count,
  input logic [N-1:0] unit_hit,
  input logic         bp_event
);
  p_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
    unit_count == 5'(N));

  p_event_or_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bp_event == (|unit_hit));

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |=> (unit_hit == '0));

  p_event_needs_fetch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid == 1'b0) |=> !bp_event);

  p_bad_priv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && priv_lvl == 2'd3) |=> (unit_hit == '0));
endmodule

bind bp_bank bp_bank_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .priv_lvl(priv_lvl),
  .unit_count(unit_count), .unit_hit(unit_hit), .bp_event(bp_event)
);

// File: tb/sim_bp_bank.sv
`timescale 1ns/1ps
module sim_bp_bank;
  localparam int N = 4;
  localparam int VAL_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_unit = '0;
  logic wr_sel = 1'b0;
  logic [VAL_W-1:0] wr_data = '0;
  logic fetch_valid = 1'b0;
  logic [31:0] fetch_va = '0;
  logic [15:0] ctx_app = '0, ctx_os = '0, vmid = '0;
  logic [1:0] priv_lvl = '0;
  logic [4:0] unit_count;
  logic [N-1:0] unit_hit;
  logic bp_event;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct { logic [N-1:0] hits; string tag; } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  bp_bank #(.N(N)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_unit(wr_unit), .wr_sel(wr_sel),
    .wr_data(wr_data), .fetch_valid(fetch_valid), .fetch_va(fetch_va),
    .ctx_app(ctx_app), .ctx_os(ctx_os), .vmid(vmid), .priv_lvl(priv_lvl),
    .unit_count(unit_count), .unit_hit(unit_hit), .bp_event(bp_event)
  );

  function automatic logic [31:0] cw(bit en, logic [2:0] m, logic [3:0] k, logic [3:0] l);
    return {20'b0, l, k, m, en};
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(int unit, bit sel, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_unit = 4'(unit); wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic fetch(logic [31:0] va, logic [15:0] app, logic [15:0] os,
                       logic [15:0] vm, logic [1:0] pl, logic [N-1:0] exp, string tag);
    exp_t e;
    @(negedge clk);
    fetch_va = va; ctx_app = app; ctx_os = os; vmid = vm; priv_lvl = pl;
    fetch_valid = 1'b1;
    e.hits = exp; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    fetch_valid = 1'b0;
  endtask

  // Monitor: pops the expected item for every accepted fetch
  initial forever begin
    @(posedge clk);
    if (fetch_valid === 1'b1) begin
      exp_t e;
      #1;
      if (q.size() == 0) begin
        check(1'b0, "scoreboard empty", 32'(unit_hit), 32'hx);
      end else begin
        e = q.pop_front();
        check(unit_hit === e.hits, {e.tag, " hits"}, 32'(unit_hit), 32'(e.hits));
        check(bp_event === (|e.hits), {e.tag, " event R10"}, 32'(bp_event), 32'(|e.hits));
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(unit_hit === '0, "R2 reset hits", 32'(unit_hit), 0);
    check(bp_event === 1'b0, "R2 reset event", 32'(bp_event), 0);
    check(unit_count === 5'd4, "R1 unit count", 32'(unit_count), 4);
    fetch(32'h0, 16'h0, 16'h0, 16'h0, 2'd0, 4'b0000, "R2 all disabled");

    // R3 unlinked address
    wr(0, 0, 32'h1000);
    wr(0, 1, cw(1, 3'b111, 4'd0, 4'd0));
    fetch(32'h1000, 0, 0, 0, 2'd1, 4'b0001, "R3 exact address");
    fetch(32'h1003, 0, 0, 0, 2'd1, 4'b0001, "R3 low bits ignored");
    fetch(32'h1004, 0, 0, 0, 2'd1, 4'b0000, "R3 next word");

    // R4 privilege mask
    wr(0, 1, cw(1, 3'b001, 4'd0, 4'd0));
    fetch(32'h1000, 0, 0, 0, 2'd1, 4'b0000, "R4 level 1 masked");
    fetch(32'h1000, 0, 0, 0, 2'd0, 4'b0001, "R4 level 0 allowed");
    wr(0, 1, cw(1, 3'b111, 4'd0, 4'd0));
    fetch(32'h1000, 0, 0, 0, 2'd3, 4'b0000, "R4 code 3");
    wr(0, 1, cw(0, 3'b111, 4'd0, 4'd0));
    fetch(32'h1000, 0, 0, 0, 2'd0, 4'b0000, "R2 enable cleared");

    // R5 context kinds
    wr(1, 0, 32'h0000_0055);
    wr(1, 1, cw(1, 3'b111, 4'd2, 4'd0));
    fetch(0, 16'h55, 16'h66, 0, 2'd0, 4'b0010, "R5 app context");
    fetch(0, 16'h66, 16'h55, 0, 2'd0, 4'b0000, "R5 app vs os");
    wr(1, 1, cw(1, 3'b111, 4'd4, 4'd0));
    fetch(0, 16'h66, 16'h55, 0, 2'd0, 4'b0010, "R5 os context");
    wr(1, 1, cw(1, 3'b111, 4'd6, 4'd0));
    fetch(0, 16'h55, 16'h66, 0, 2'd0, 4'b0000, "R5 both one equal");
    fetch(0, 16'h55, 16'h55, 0, 2'd0, 4'b0010, "R5 both equal");

    // R6 VMID
    wr(2, 0, 32'h0000_0007);
    wr(2, 1, cw(1, 3'b111, 4'd8, 4'd0));
    fetch(0, 0, 0, 16'h7, 2'd2, 4'b0100, "R6 vmid match");
    fetch(0, 0, 0, 16'h8, 2'd2, 4'b0000, "R6 vmid mismatch");

    // R7 context + VMID
    wr(2, 0, 32'h0007_0055);
    wr(2, 1, cw(1, 3'b111, 4'd10, 4'd0));
    fetch(0, 16'h55, 0, 16'h7, 2'd1, 4'b0100, "R7 ctx and vmid");
    fetch(0, 16'h56, 0, 16'h7, 2'd1, 4'b0000, "R7 ctx differs");
    fetch(0, 16'h7, 0, 16'h55, 2'd1, 4'b0000, "R7 halves swapped");
    wr(1, 1, 32'h0);

    // R8 linked context alone
    wr(3, 0, 32'h0000_0055);
    wr(3, 1, cw(1, 3'b111, 4'd3, 4'd0));
    fetch(0, 16'h55, 0, 0, 2'd0, 4'b0000, "R8 linked ctx alone");

    // R9 linked address
    wr(0, 0, 32'h2000);
    wr(0, 1, cw(1, 3'b111, 4'd1, 4'd3));
    fetch(32'h2000, 16'h55, 0, 0, 2'd0, 4'b0001, "R9 address and context");
    fetch(32'h2000, 16'h56, 0, 0, 2'd0, 4'b0000, "R9 context differs");
    fetch(32'h2004, 16'h55, 0, 0, 2'd0, 4'b0000, "R9 address differs");
    wr(0, 1, cw(1, 3'b111, 4'd1, 4'd2));
    fetch(32'h2000, 16'h55, 0, 0, 2'd0, 4'b0000, "R9 link to unlinked kind");
    wr(0, 1, cw(1, 3'b111, 4'd1, 4'd1));
    fetch(32'h2000, 16'h55, 0, 0, 2'd0, 4'b0000, "R9 link to disabled unit");
    wr(0, 1, cw(1, 3'b111, 4'd1, 4'd9));
    fetch(32'h2000, 16'h55, 0, 0, 2'd0, 4'b0000, "R9 link out of range");
    wr(0, 1, cw(1, 3'b111, 4'd1, 4'd3));
    wr(3, 1, cw(0, 3'b111, 4'd3, 4'd0));
    fetch(32'h2000, 16'h55, 0, 0, 2'd0, 4'b0000, "R9 target disabled");

    // R11 out-of-range write
    wr(5, 0, 32'h3000);
    wr(5, 1, cw(1, 3'b111, 4'd0, 4'd0));
    fetch(32'h3000, 0, 0, 0, 2'd0, 4'b0000, "R11 index 5 ignored");

    // R10 multiple hits and idle cycle
    wr(0, 1, cw(1, 3'b111, 4'd0, 4'd0));
    wr(2, 0, 32'h0000_0007);
    wr(2, 1, cw(1, 3'b111, 4'd8, 4'd0));
    fetch(32'h2000, 0, 0, 16'h7, 2'd0, 4'b0101, "R10 two units");
    @(negedge clk);
    fetch_va = 32'h2000; vmid = 16'h7; fetch_valid = 1'b0;
    @(posedge clk); #1;
    check(unit_hit === '0, "R10 no fetch hits", 32'(unit_hit), 0);
    check(bp_event === 1'b0, "R10 no fetch event", 32'(bp_event), 0);

    repeat (3) @(negedge clk);
    check(q.size() == 0, "scoreboard drained", q.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule